// File: doc/BRIEF.md
# Address-space-tagged translation lookaside buffer

This block caches virtual-to-physical page mappings for a 32-bit virtual address space split into 4 kB pages. A virtual address and the current address space identifier enter on a valid/ready request stream. Two cycles later a response stream returns a hit flag and the physical address. The physical address is built from the cached physical page number and the untouched 12-bit page offset. The store is fully associative with 16 entries. Every entry holds a valid flag, a virtual page number, an address space identifier and a physical page number.

A miss is only reported. Whoever walks the page table writes the mapping back through the refill port. Stale mappings are removed through three invalidation controls: one page of one address space, every entry of one address space, or the whole store.

The request side accepts a request whenever `req_ready` is high in a cycle where `req_valid` is high. The response side holds `rsp_valid` and its payload unchanged until `rsp_ready` is seen high. While the response is stalled, the two pipeline stages fill up and `req_ready` drops.

A lookup compares against the entry store as it stands in the cycle after acceptance. The refill and invalidation controls are plain single-cycle strobes.

Top module: `asid_tlb`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1 and every entry is invalid, so any lookup misses.
- R2: A request accepted in cycle c produces `rsp_valid` in cycle c+2 when the response side is not stalled, and not in cycle c+1.
- R3: While `rsp_valid` is 1 and `rsp_ready` is 0, the response payload stays unchanged. Once both stages hold a request and `rsp_ready` is 0, `req_ready` is 0. Stalled requests are delivered in order with nothing lost.
- R4: A hit requires a valid entry whose page number (virtual address bits 31:12) and identifier both equal the request. On a hit, `rsp_paddr` is the entry's physical page number in bits 31:12 followed by the request's offset bits 11:0. On a miss, `rsp_hit` is 0, bits 31:12 are zero and bits 11:0 still carry the offset.
- R5: A refill whose page number and identifier match a valid entry overwrites that entry, so a later lookup returns the new page and no duplicate remains.
- R6: A refill with no matching entry uses the lowest-indexed invalid entry. When every entry is valid, it uses a round-robin pointer. The pointer starts at entry 0 after reset and advances by one only on such an eviction.
- R7: A page invalidate clears only the entry that matches both its page number and its identifier. The same page under another identifier stays valid.
- R8: An address-space invalidate clears every entry carrying its identifier in one cycle and leaves the entries of other identifiers valid.
- R9: A full invalidate clears every entry in one cycle and takes precedence over a refill in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be taken this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_asid | input | 8 | Address space identifier of the request |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer takes the result this cycle |
| rsp_hit | output | 1 | 1 when a mapping was found |
| rsp_paddr | output | 32 | Physical address, page zeroed on a miss |
| fill_en | input | 1 | Write one mapping |
| fill_vpn | input | 20 | Virtual page number of the refill |
| fill_asid | input | 8 | Identifier of the refill |
| fill_ppn | input | 20 | Physical page number of the refill |
| inv_page_en | input | 1 | Invalidate the entry matching `inv_vpn` and `inv_asid` |
| inv_space_en | input | 1 | Invalidate every entry carrying `inv_asid` |
| inv_all_en | input | 1 | Invalidate every entry |
| inv_vpn | input | 20 | Page number for a page invalidate |
| inv_asid | input | 8 | Identifier for page or address-space invalidates |

## Verification
The bench places one page under two identifiers and looks it up under a third. A design that compared only page numbers would return the wrong physical page or hit where it must miss. It refills a mapping that already exists and then invalidates that page. A design that made a duplicate would keep hitting on the old page. It fills all sixteen entries, evicts twice and then frees one slot, to tell round-robin order apart from free-slot preference. A pointer that started wrong or advanced on every refill would evict the wrong mapping. It stalls the response stream with three requests in flight. A design without correct back-pressure would lose the middle request or change the held payload.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    VSEL_MATCH = 2'd0,
    VSEL_FREE  = 2'd1,
    VSEL_RR    = 2'd2
  } vsel_e;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_active,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [ASID_W-1:0]  lk_asid,
  output logic               lk_hit,
  output logic [PPN_W-1:0]   lk_ppn,
  input  logic [VPN_W-1:0]   fl_vpn,
  input  logic [ASID_W-1:0]  fl_asid,
  output logic [ENTRIES-1:0] fl_match,
  output logic [ENTRIES-1:0] valid_vec,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [PPN_W-1:0]   wr_ppn,
  input  logic               inv_page_en,
  input  logic               inv_space_en,
  input  logic               inv_all_en,
  input  logic [VPN_W-1:0]   inv_vpn,
  input  logic [ASID_W-1:0]  inv_asid
);
  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [ENTRIES-1:0] lk_match, pg_kill, sp_kill;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign lk_match[e] = valid_q[e] && vpn_q[e] == lk_vpn && asid_q[e] == lk_asid;
    assign fl_match[e] = valid_q[e] && vpn_q[e] == fl_vpn && asid_q[e] == fl_asid;
    assign pg_kill[e]  = inv_page_en && vpn_q[e] == inv_vpn && asid_q[e] == inv_asid;
    assign sp_kill[e]  = inv_space_en && asid_q[e] == inv_asid;
  end

  always_comb begin
    lk_ppn = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (lk_match[e]) lk_ppn = lk_ppn | ppn_q[e];
    end
  end

  assign lk_hit    = |lk_match;
  assign valid_vec = valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (inv_all_en) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_q & ~(pg_kill | sp_kill);
      if (wr_en) valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !inv_all_en) begin
      vpn_q[wr_idx]  <= fl_vpn;
      asid_q[wr_idx] <= fl_asid;
      ppn_q[wr_idx]  <= wr_ppn;
    end
  end

  // R5: refill-in-place keeps mappings unique
  assert_single_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_active |-> $onehot0(lk_match));

  // R9: a full invalidate empties the store
  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all_en |=> valid_vec == '0);
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_en,
  input  logic [ENTRIES-1:0] fl_match,
  input  logic [ENTRIES-1:0] valid_vec,
  output logic [IDX_W-1:0]   wr_idx
);
  logic [IDX_W-1:0] rr_q, free_idx, hit_idx;
  vsel_e            sel;

  always_comb begin
    free_idx = '0;
    hit_idx  = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!valid_vec[e]) free_idx = IDX_W'(e);
      if (fl_match[e])   hit_idx  = IDX_W'(e);
    end
    if (|fl_match)         sel = VSEL_MATCH;
    else if (!(&valid_vec)) sel = VSEL_FREE;
    else                   sel = VSEL_RR;
    case (sel)
      VSEL_MATCH: wr_idx = hit_idx;
      VSEL_FREE:  wr_idx = free_idx;
      default:    wr_idx = rr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (fill_en && sel == VSEL_RR) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  // R6: a new mapping never displaces a live entry while a free one exists
  assert_free_slot_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !(|fl_match) && !(&valid_vec)) |-> !valid_vec[wr_idx]);
endmodule

// File: rtl/tlb_lookup_pipe.sv
module tlb_lookup_pipe #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int PAGE_W = 12,
  parameter int ASID_W = 8,
  localparam int VPN_W = VA_W - PAGE_W,
  localparam int PPN_W = PA_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [ASID_W-1:0] req_asid,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              lk_active,
  output logic [VPN_W-1:0]  lk_vpn,
  output logic [ASID_W-1:0] lk_asid,
  input  logic              lk_hit,
  input  logic [PPN_W-1:0]  lk_ppn
);
  logic              s1_v, s2_v, s2_hit, adv1, adv2;
  logic [PAGE_W-1:0] s1_ofs, s2_ofs;
  logic [PPN_W-1:0]  s2_ppn;

  assign adv2      = !s2_v || rsp_ready;
  assign adv1      = !s1_v || adv2;
  assign req_ready = adv1;
  assign lk_active = s1_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else begin
      if (adv1) s1_v <= req_valid;
      if (adv2) s2_v <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    if (adv1 && req_valid) begin
      lk_vpn  <= req_vaddr[VA_W-1:PAGE_W];
      lk_asid <= req_asid;
      s1_ofs  <= req_vaddr[PAGE_W-1:0];
    end
    if (adv2 && s1_v) begin
      s2_hit <= lk_hit;
      s2_ppn <= lk_hit ? lk_ppn : '0;
      s2_ofs <= s1_ofs;
    end
  end

  assign rsp_valid = s2_v;
  assign rsp_hit   = s2_hit;
  assign rsp_paddr = {s2_ppn, s2_ofs};

  // R3: a stalled response is held
  assert_hold_stalled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_hit)));

  // R4: a miss carries no physical page
  assert_miss_page_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> rsp_paddr[PA_W-1:PAGE_W] == '0);
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PAGE_W  = 12,
  parameter int ASID_W  = 8,
  localparam int VPN_W  = VA_W - PAGE_W,
  localparam int PPN_W  = PA_W - PAGE_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [ASID_W-1:0] req_asid,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [PA_W-1:0]   rsp_paddr,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic              inv_page_en,
  input  logic              inv_space_en,
  input  logic              inv_all_en,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic [ASID_W-1:0] inv_asid
);
  logic               lk_active, lk_hit;
  logic [VPN_W-1:0]   lk_vpn;
  logic [ASID_W-1:0]  lk_asid;
  logic [PPN_W-1:0]   lk_ppn;
  logic [ENTRIES-1:0] fl_match, valid_vec;
  logic [IDX_W-1:0]   wr_idx;

  tlb_lookup_pipe #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W), .ASID_W(ASID_W)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_asid(req_asid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
    .lk_active(lk_active), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn)
  );

  tlb_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .lk_active(lk_active), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .fl_vpn(fill_vpn), .fl_asid(fill_asid), .fl_match(fl_match),
    .valid_vec(valid_vec),
    .wr_en(fill_en), .wr_idx(wr_idx), .wr_ppn(fill_ppn),
    .inv_page_en(inv_page_en), .inv_space_en(inv_space_en), .inv_all_en(inv_all_en),
    .inv_vpn(inv_vpn), .inv_asid(inv_asid)
  );

  tlb_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en), .fl_match(fl_match), .valid_vec(valid_vec),
    .wr_idx(wr_idx)
  );
endmodule

// File: tb/test_asid_tlb.sv
`timescale 1ns/1ps
module test_asid_tlb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, rsp_valid, rsp_ready, rsp_hit;
  logic [31:0] req_vaddr, rsp_paddr;
  logic [7:0]  req_asid, fill_asid, inv_asid;
  logic        fill_en, inv_page_en, inv_space_en, inv_all_en;
  logic [19:0] fill_vpn, fill_ppn, inv_vpn;
  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  asid_tlb i_asid_tlb (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_asid(req_asid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_ppn(fill_ppn),
    .inv_page_en(inv_page_en), .inv_space_en(inv_space_en), .inv_all_en(inv_all_en),
    .inv_vpn(inv_vpn), .inv_asid(inv_asid)
  );

  // {vaddr, asid, expected hit, expected paddr}
  localparam logic [72:0] VEC [0:7] = '{
    {32'h00001ABC, 8'd1, 1'b1, 32'hAAAAAABC},
    {32'h00001ABC, 8'd2, 1'b1, 32'hBBBBBABC},
    {32'h00001000, 8'd3, 1'b0, 32'h00000000},
    {32'hFFFFFFFF, 8'd1, 1'b1, 32'h12345FFF},
    {32'hFFFFF123, 8'd2, 1'b0, 32'h00000123},
    {32'h40000555, 8'd3, 1'b1, 32'h00007555},
    {32'h00002ABC, 8'd1, 1'b0, 32'h00000ABC},
    {32'h40000000, 8'd1, 1'b0, 32'h00000000}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [7:0] asid, input logic [19:0] ppn);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = vpn; fill_asid = asid; fill_ppn = ppn;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic inval(input int kind, input logic [19:0] vpn, input logic [7:0] asid);
    @(negedge clk);
    inv_vpn = vpn; inv_asid = asid;
    inv_page_en  = (kind == 0);
    inv_space_en = (kind == 1);
    inv_all_en   = (kind == 2);
    @(negedge clk);
    inv_page_en = 1'b0; inv_space_en = 1'b0; inv_all_en = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input bit eh,
                        input logic [31:0] ep, input string tag);
    @(negedge clk);
    rsp_ready = 1'b1;
    req_valid = 1'b1; req_vaddr = va; req_asid = asid;
    chk(req_ready == 1'b1, {tag, " R3 ready idle"}, 32'(req_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b0, {tag, " R2 early"}, 32'(rsp_valid), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b1, {tag, " R2 valid"}, 32'(rsp_valid), 32'd1);
    chk(rsp_hit == eh, {tag, " hit"}, 32'(rsp_hit), 32'(eh));
    chk(rsp_paddr == ep, {tag, " paddr"}, rsp_paddr, ep);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_vaddr = '0; req_asid = '0; rsp_ready = 1'b1;
    fill_en = 1'b0; fill_vpn = '0; fill_asid = '0; fill_ppn = '0;
    inv_page_en = 1'b0; inv_space_en = 1'b0; inv_all_en = 1'b0; inv_vpn = '0; inv_asid = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
    lookup(32'h00000010, 8'd0, 1'b0, 32'h00000010, "R1 empty");

    // table walk: R4 page and identifier both needed
    fill(20'h00001, 8'd1, 20'hAAAAA);
    fill(20'h00001, 8'd2, 20'hBBBBB);
    fill(20'hFFFFF, 8'd1, 20'h12345);
    fill(20'h40000, 8'd3, 20'h00007);
    for (int i = 0; i < 8; i++) begin
      lookup(VEC[i][72:41], VEC[i][40:33], VEC[i][32], VEC[i][31:0], $sformatf("R4 vec%0d", i));
    end

    // R3: stall with three requests in flight
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_vaddr = 32'h00001ABC; req_asid = 8'd1;
    @(posedge clk);
    @(negedge clk);
    req_vaddr = 32'hFFFFF001; req_asid = 8'd1;
    @(posedge clk);
    @(negedge clk);
    req_vaddr = 32'h40000002; req_asid = 8'd3;
    chk(rsp_valid && rsp_paddr == 32'hAAAAAABC, "R3 first held", rsp_paddr, 32'hAAAAAABC);
    chk(req_ready == 1'b0, "R3 ready low", 32'(req_ready), 32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rsp_valid && rsp_paddr == 32'hAAAAAABC, "R3 still held", rsp_paddr, 32'hAAAAAABC);
    chk(req_ready == 1'b0, "R3 ready still low", 32'(req_ready), 32'd0);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_paddr == 32'h12345001, "R3 second", rsp_paddr, 32'h12345001);
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid && rsp_paddr == 32'h00007002, "R3 third", rsp_paddr, 32'h00007002);
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R3 drained", 32'(rsp_valid), 32'd0);

    // R5: refill in place, then R7 page invalidate
    fill(20'h00001, 8'd1, 20'h55555);
    lookup(32'h00001ABC, 8'd1, 1'b1, 32'h55555ABC, "R5 overwrite");
    inval(0, 20'h00001, 8'd1);
    lookup(32'h00001ABC, 8'd1, 1'b0, 32'h00000ABC, "R5 no duplicate");
    lookup(32'h00001ABC, 8'd2, 1'b1, 32'hBBBBBABC, "R7 other id kept");
    lookup(32'hFFFFF000, 8'd1, 1'b1, 32'h12345000, "R7 other page kept");

    // R8 address-space invalidate
    inval(1, 20'h0, 8'd1);
    lookup(32'hFFFFF000, 8'd1, 1'b0, 32'h00000000, "R8 cleared");
    lookup(32'h00001ABC, 8'd2, 1'b1, 32'hBBBBBABC, "R8 id2 kept");
    lookup(32'h40000004, 8'd3, 1'b1, 32'h00007004, "R8 id3 kept");

    // R9 full invalidate, winning over a same-cycle refill
    @(negedge clk);
    inv_all_en = 1'b1;
    fill_en = 1'b1; fill_vpn = 20'h00077; fill_asid = 8'd4; fill_ppn = 20'h00099;
    @(negedge clk);
    inv_all_en = 1'b0; fill_en = 1'b0;
    lookup(32'h40000004, 8'd3, 1'b0, 32'h00000004, "R9 cleared");
    lookup(32'h00077000, 8'd4, 1'b0, 32'h00000000, "R9 beats refill");

    // R6 replacement order
    for (int i = 0; i < 16; i++) fill(20'h00100 + 20'(i), 8'd5, 20'h00200 + 20'(i));
    lookup(32'h0010F008, 8'd5, 1'b1, 32'h0020F008, "R6 full store");
    fill(20'h00300, 8'd5, 20'h00400);
    lookup(32'h00100000, 8'd5, 1'b0, 32'h00000000, "R6 evict slot0");
    lookup(32'h00101000, 8'd5, 1'b1, 32'h00201000, "R6 slot1 kept");
    lookup(32'h00300000, 8'd5, 1'b1, 32'h00400000, "R6 new entry");
    fill(20'h00301, 8'd5, 20'h00401);
    lookup(32'h00101000, 8'd5, 1'b0, 32'h00000000, "R6 evict slot1");
    inval(0, 20'h00105, 8'd5);
    fill(20'h00302, 8'd5, 20'h00402);
    lookup(32'h00102000, 8'd5, 1'b1, 32'h00202000, "R6 free slot preferred");
    lookup(32'h00302000, 8'd5, 1'b1, 32'h00402000, "R6 free slot used");
    fill(20'h00303, 8'd5, 20'h00403);
    lookup(32'h00102000, 8'd5, 1'b0, 32'h00000000, "R6 pointer held at slot2");
    lookup(32'h00103000, 8'd5, 1'b1, 32'h00203000, "R6 slot3 kept");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule